// File: doc/BRIEF.md
# Dual Prescaled Timer with Selectable Square-Wave Output

This block holds two independent interval timers. Each timer runs from a common divide-by-four tick of the system clock. The tick feeds a 6-bit prescaler, and the prescaler feeds an 8-bit down-counter. Both stages count down to one and then reload, so a programmed value n divides by n. A programmed value of zero divides by the full range of the stage: 64 for the prescaler and 256 for the counter. Each time a counter reaches its terminal count, that timer's wave flop toggles, which gives a square wave.

A mode register does four things: it starts and stops each timer, it restarts either timer on request, and it picks what drives the single output pin. The choices are a constant low, timer 0's wave, timer 1's wave, or the raw system clock. A separate write-only pin-mode register has one bit that takes the pin away from the timers. While that bit is set, the output enable is low and the pin is held low. Software reaches all registers through a small address/data bus with a write strobe. Reads are combinational.

Top module: `tmr_pair_out`

## Requirements
- R1: After reset, both timers are stopped, the mode register reads 0x00, the output select is "off", `tout_o` is 0 and `tout_oe_o` is 1.
- R2: The mode register at address 0 reads back bits 7:6 (output select), bit 3 (timer 1 run) and bit 1 (timer 0 run) as written. Bit 2 (restart timer 1) and bit 0 (restart timer 0) always read 0. The pin-mode register at address 5 always reads 0x00.
- R3: When timer 0 runs with a prescaler value P (address 2) and a reload value N (address 1), each half period of its wave lasts exactly 4·P·N system clocks.
- R4: A prescaler value of 0 counts as 64, and a reload value of 0 counts as 256.
- R5: Output select encoding in mode bits 7:6: 00 drives the pin low, 01 selects timer 0's wave, 10 selects timer 1's wave, and 11 passes the system clock itself.
- R6: When pin-mode bit 5 is 1, `tout_oe_o` is 0 and `tout_o` is 0. When that bit is 0, `tout_oe_o` is 1.
- R7: Writing 1 to a restart bit reloads that timer's prescaler and counter. Writing 0 to a restart bit leaves the running count undisturbed.
- R8: While a timer's run bit is 0, its counter value and its wave hold still.
- R9: Timer 1 (prescaler at address 4, reload at address 3, run in bit 3, restart in bit 2) behaves by the same rules as timer 0 and runs independently of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| tout_o | output | 1 | Shared timer output pin |
| tout_oe_o | output | 1 | Output enable for the pin |

## Verification
The main timing path is tried with four divisor pairs: 1×1, 2×3, 64×1 and 1×256. The smallest pair exposes any off-by-one cycle in the tick or the reload. The middle pair separates prescaler depth from counter depth. The two zero-encoded pairs show whether zero is taken as the full range or as zero. A rewrite of the mode register in the middle of a period, with the restart bit clear, must leave the measured interval unchanged. The same period checks are then repeated with timer 1 selected, which separates the two timers and the select codes, and the clock and pin-gating modes are probed in both clock phases.

// File: rtl/tmr_pair_pkg.sv
// Package: shared widths, register addresses and output-select codes
// for the dual prescaled timer. Assumes an 8-bit register bus.
package tmr_pair_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_MODE   = 3'd0,
        REG_T0_REL = 3'd1,
        REG_T0_PRE = 3'd2,
        REG_T1_REL = 3'd3,
        REG_T1_PRE = 3'd4,
        REG_PINCFG = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        OSEL_OFF = 2'b00,
        OSEL_T0  = 2'b01,
        OSEL_T1  = 2'b10,
        OSEL_CLK = 2'b11
    } osel_e;

    // Bit positions inside the mode register
    localparam int MB_LD0  = 0;
    localparam int MB_EN0  = 1;
    localparam int MB_LD1  = 2;
    localparam int MB_EN1  = 3;
    localparam int MB_SELL = 6;
    localparam int MB_SELH = 7;
    // Pin-mode bit that hands the pin to another function
    localparam int PB_HAND = 5;
endpackage

// File: rtl/tmr_tick_div.sv
// Module: free-running divider that issues a one-clock tick every
// DIV-th system clock. Assumes DIV is a power of two of at least 2.
module tmr_tick_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int DW = $clog2(DIV);

    logic [DW-1:0] div_q;

    // Count system clocks; wraps naturally at DIV
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    assign tick_o = (div_q == DW'(DIV - 1));
endmodule

// File: rtl/tmr_channel.sv
// Module: one timer channel. A prescaler of PRE_W bits feeds a counter of
// CNT_W bits. Both count down to 1 and then reload, so a value of 0 gives
// the full 2**W range. The wave flop toggles at each counter terminal.
// Assumes tick_i is a single-clock pulse, and that a restart request
// takes priority over counting.
module tmr_channel #(
    parameter int PRE_W = 6,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [PRE_W-1:0] pre_val_i,
    input  logic [CNT_W-1:0] rel_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wave_o
);
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wave_q;
    logic             pre_end;
    logic             cnt_end;

    assign pre_end = run_i && tick_i && (pre_q == PRE_W'(1));
    assign cnt_end = pre_end && (cnt_q == CNT_W'(1));

    // Prescaler stage: divide ticks by pre_val (0 means the full range)
    always_ff @(posedge clk) begin
        if (!rst_n)                pre_q <= '0;
        else if (restart_i)        pre_q <= pre_val_i;
        else if (pre_end)          pre_q <= pre_val_i;
        else if (run_i && tick_i)  pre_q <= pre_q - 1'b1;
    end

    // Counter stage: divide prescaler outputs by rel_val
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (restart_i)  cnt_q <= rel_val_i;
        else if (cnt_end)    cnt_q <= rel_val_i;
        else if (pre_end)    cnt_q <= cnt_q - 1'b1;
    end

    // Square-wave flop toggles on each terminal count
    always_ff @(posedge clk) begin
        if (!rst_n)       wave_q <= 1'b0;
        else if (cnt_end) wave_q <= ~wave_q;
    end

    assign cnt_o  = cnt_q;
    assign wave_o = wave_q;
endmodule

// File: rtl/tmr_regs.sv
// Module: register file for the timer pair. It holds the mode, the two
// reload values, the two prescaler values and the pin-mode register.
// Restart bits are not stored: writing 1 to one of them gives a one-clock
// pulse. Reads are combinational; pin-mode and restart bits read as 0.
module tmr_regs
    import tmr_pair_pkg::*;
#(
    parameter int PRE_W = 6,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [1:0]        run_o,
    output logic [1:0]        restart_o,
    output logic [PRE_W-1:0]  pre_o [2],
    output logic [CNT_W-1:0]  rel_o [2],
    output osel_e             osel_o,
    output logic              hand_o
);
    logic [DATA_W-1:0] mode_q;
    logic              hand_q;
    logic [PRE_W-1:0]  pre_q [2];
    logic [CNT_W-1:0]  rel_q [2];
    logic              wr_mode;

    assign wr_mode = we_i && (addr_i == REG_MODE);

    // Mode register: keep select and run bits, drop restart bits
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (wr_mode) mode_q <= wdata_i & ~(DATA_W'(1) << MB_LD0)
                                            & ~(DATA_W'(1) << MB_LD1);
    end

    // Pin-mode register: only the hand-over bit is kept
    always_ff @(posedge clk) begin
        if (!rst_n)                            hand_q <= 1'b0;
        else if (we_i && addr_i == REG_PINCFG) hand_q <= wdata_i[PB_HAND];
    end

    // Per-timer divisor registers, one pair of addresses per timer
    for (genvar g = 0; g < 2; g++) begin : g_div
        localparam logic [ADDR_W-1:0] A_REL = ADDR_W'(1 + 2*g);
        localparam logic [ADDR_W-1:0] A_PRE = ADDR_W'(2 + 2*g);
        // Latch reload and prescaler values on their writes
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rel_q[g] <= '0;
                pre_q[g] <= '0;
            end else if (we_i) begin
                if (addr_i == A_REL) rel_q[g] <= wdata_i[CNT_W-1:0];
                if (addr_i == A_PRE) pre_q[g] <= wdata_i[PRE_W-1:0];
            end
        end
        assign pre_o[g] = pre_q[g];
        assign rel_o[g] = rel_q[g];
    end

    assign run_o     = {mode_q[MB_EN1], mode_q[MB_EN0]};
    assign restart_o = {wr_mode && wdata_i[MB_LD1], wr_mode && wdata_i[MB_LD0]};
    assign osel_o    = osel_e'(mode_q[MB_SELH:MB_SELL]);
    assign hand_o    = hand_q;

    // Read mux: pin-mode and unmapped addresses return zero
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            REG_MODE:   rdata_o = mode_q;
            REG_T0_REL: rdata_o = DATA_W'(rel_q[0]);
            REG_T0_PRE: rdata_o = DATA_W'(pre_q[0]);
            REG_T1_REL: rdata_o = DATA_W'(rel_q[1]);
            REG_T1_PRE: rdata_o = DATA_W'(pre_q[1]);
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/tmr_pair_out.sv
// Module: top of the dual prescaled timer. It joins the register file,
// the shared tick divider and two timer channels, and drives the output
// pin through the select mux and the pin-mode gate. Assumes the clock
// may be passed to the pin directly in clock-select mode.
module tmr_pair_out
    import tmr_pair_pkg::*;
#(
    parameter int TICK_DIV = 4,
    parameter int PRE_W    = 6,
    parameter int CNT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tout_o,
    output logic              tout_oe_o
);
    logic [1:0]       run;
    logic [1:0]       restart;
    logic [PRE_W-1:0] pre_v [2];
    logic [CNT_W-1:0] rel_v [2];
    logic [CNT_W-1:0] cnt_v [2];
    logic [1:0]       wave;
    osel_e            osel;
    logic             hand;
    logic             tick;
    logic             mux_out;

    tmr_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .we_i(bus_we), .rdata_o(bus_rdata), .run_o(run), .restart_o(restart),
        .pre_o(pre_v), .rel_o(rel_v), .osel_o(osel), .hand_o(hand)
    );

    tmr_tick_div #(.DIV(TICK_DIV)) tick_i (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    for (genvar g = 0; g < 2; g++) begin : g_ch
        tmr_channel #(.PRE_W(PRE_W), .CNT_W(CNT_W)) ch_i (
            .clk(clk), .rst_n(rst_n), .tick_i(tick), .run_i(run[g]),
            .restart_i(restart[g]), .pre_val_i(pre_v[g]),
            .rel_val_i(rel_v[g]), .cnt_o(cnt_v[g]), .wave_o(wave[g])
        );
    end

    // Output source select
    always_comb begin
        case (osel)
            OSEL_T0:  mux_out = wave[0];
            OSEL_T1:  mux_out = wave[1];
            OSEL_CLK: mux_out = clk;
            default:  mux_out = 1'b0;
        endcase
    end

    assign tout_oe_o = ~hand;
    assign tout_o    = tout_oe_o & mux_out;
endmodule

// File: rtl/tmr_pair_chk.sv
// Module: assertion checker bound into the timer top. It watches the pin,
// the select, the read bus and timer 0's run state and count.
module tmr_pair_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] osel,
    input logic       tout_o,
    input logic       tout_oe_o,
    input logic [2:0] bus_addr,
    input logic [7:0] bus_rdata,
    input logic       run0,
    input logic       restart0,
    input logic [7:0] cnt0
);
    // R6: a released pin is never driven high
    assert_gate_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tout_oe_o |-> !tout_o);

    // R5: select code 00 keeps the pin low
    assert_off_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (osel == 2'b00) |-> !tout_o);

    // R2: restart bits of the mode register never read back as 1
    assert_restart_rd0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd0) |-> (bus_rdata[0] == 1'b0 && bus_rdata[2] == 1'b0));

    // R8: a stopped timer without restart keeps its count
    assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run0 && !restart0) |=> $stable(cnt0));

    // R2: the pin-mode register reads as zero
    assert_pincfg_rd0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd5) |-> (bus_rdata == 8'h00));
endmodule

bind tmr_pair_out tmr_pair_chk chk_i (
    .clk(clk), .rst_n(rst_n), .osel(osel), .tout_o(tout_o),
    .tout_oe_o(tout_oe_o), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .run0(run[0]), .restart0(restart[0]), .cnt0(cnt_v[0])
);

// File: tb/tmr_pair_out_tb_top.sv
// Scoreboard bench: the driver pushes expected half-period lengths and
// the monitor measures the intervals between pin edges against them.
module tmr_pair_out_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       tout_o;
    logic       tout_oe_o;

    typedef struct { int iv; string tag; } exp_t;
    exp_t exp_q[$];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_edge = 0;
    int edge_cnt = 0;
    logic prev_tout = 1'b0;
    bit done = 0;

    always #5 clk = ~clk;

    tmr_pair_out dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .tout_o(tout_o),
        .tout_oe_o(tout_oe_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: detect pin edges between clock edges, compare intervals
    always @(negedge clk) begin
        if (tout_o !== prev_tout) begin
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (cyc - last_edge != e.iv) begin
                    errors++;
                    $display("FAIL %s half period actual=%0d expected=%0d",
                             e.tag, cyc - last_edge, e.iv);
                end
            end
            last_edge = cyc;
            edge_cnt++;
        end
        prev_tout = tout_o;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 chk(tag, bus_rdata, exp);
    endtask

    task automatic wait_edge();
        int n;
        n = edge_cnt;
        wait (edge_cnt != n);
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    // Driver: program one timer, sync to an edge, push expected intervals
    task automatic run_timer(input int t, input logic [7:0] pre, input logic [7:0] rel,
                             input int nexp, input string tag);
        int p, n;
        p = (pre == 0) ? 64 : int'(pre);
        n = (rel == 0) ? 256 : int'(rel);
        wr(t ? 3'd4 : 3'd2, pre);
        wr(t ? 3'd3 : 3'd1, rel);
        wr(3'd0, t ? 8'b10_00_1100 : 8'b01_00_0011);
        wait_edge();
        for (int i = 0; i < nexp; i++) exp_q.push_back('{4*p*n, tag});
        drain();
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic held;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 tout", tout_o, 0);
        chk("R1 oe", tout_oe_o, 1);
        rd_chk("R1 mode", 3'd0, 8'h00);

        // R2: readback with restart bits dropped, pin-mode write-only
        wr(3'd0, 8'b01_00_1111);
        rd_chk("R2 mode rd", 3'd0, 8'h4A);
        wr(3'd0, 8'h00);
        wr(3'd5, 8'hDF);
        rd_chk("R2 pincfg rd", 3'd5, 8'h00);
        wr(3'd5, 8'h00);

        // R3: smallest period and a mixed divisor
        run_timer(0, 8'd1, 8'd1, 3, "R3 1x1");
        run_timer(0, 8'd2, 8'd3, 3, "R3 2x3");
        // R4: zero encodes the full range
        run_timer(0, 8'd0, 8'd1, 2, "R4 pre0");

        // R7: rewrite mode mid-period with restart clear: interval unchanged
        run_timer(0, 8'd2, 8'd3, 1, "R7 setup");
        wait_edge();
        exp_q.push_back('{24, "R7 no restart"});
        repeat (10) @(posedge clk);
        wr(3'd0, 8'b01_00_0010);
        drain();

        // R8: clearing the run bit freezes the wave
        wr(3'd0, 8'b01_00_0000);
        @(negedge clk) held = tout_o;
        repeat (200) @(posedge clk);
        @(negedge clk) chk("R8 stopped", tout_o, held);

        // R5/R9: T0 stopped, T1 running but T0 selected: pin still
        wr(3'd1, 8'd1); wr(3'd2, 8'd1);
        wr(3'd0, 8'b01_00_1100);
        @(negedge clk) held = tout_o;
        repeat (60) @(posedge clk);
        @(negedge clk) chk("R9 T1 not on T0 sel", tout_o, held);
        // R9/R4: timer 1 with counter zero -> 256
        run_timer(1, 8'd1, 8'd0, 2, "R9 R4 T1 rel0");

        // R5: clock mode passes the clock
        wr(3'd0, 8'b11_00_0000);
        @(posedge clk); #1 chk("R5 clk high", tout_o, 1);
        @(negedge clk); #1 chk("R5 clk low", tout_o, 0);
        // R6: hand-over gates pin
        wr(3'd5, 8'h20);
        @(posedge clk); #1 chk("R6 oe off", tout_oe_o, 0);
        chk("R6 pin low", tout_o, 0);
        wr(3'd5, 8'h00);
        @(posedge clk); #1 chk("R6 oe on", tout_oe_o, 1);
        // R5: select off
        wr(3'd0, 8'b00_00_1010);
        repeat (40) begin
            @(negedge clk);
            if (tout_o !== 1'b0) begin
                chk("R5 off low", tout_o, 0);
                break;
            end
        end
        chk("R5 off end", tout_o, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule